// File: doc/BRIEF.md
# Eight-Line Peripheral Interrupt Unit

This block sits inside one peripheral and turns eight raw interrupt inputs into latched, individually enabled events that software reaches through a byte-wide register port. Every line has its own detection setup. A type bit chooses level or edge detection. Two polarity bits then pick the sense. In edge mode one bit arms the rising edge and the other arms the falling edge, so setting both catches either transition. In level mode one bit makes the line active-high and the other makes it active-low. The raw inputs pass through a two-flop synchronizer before detection.

The register port is synchronous. A beat is accepted on a cycle with `bus_sel` high. The beat that carries `bus_first` takes its address from `bus_addr`. Each later beat of the same access uses the previous address plus one, so one access can move several bytes. With this, software can write type and both polarities in a single three-byte write from the type address. It can also clear a latch and enable the line in one two-byte write from the clear address. Read data is registered and appears the cycle after the read beat. One request output, `irq_req`, is high whenever any enabled line has its latched bit set.

Top module: `line_irq_unit`

## Requirements
- R1: After reset every register reads zero, `bus_rdata` is zero and `irq_req` is low.
- R2: Addresses 0x11 (type), 0x12 (high polarity) and 0x13 (low polarity) can be written and read back, with line n on bit n. Beats after the first in an access use consecutive addresses for both writes and reads, so a three-byte write from 0x11 loads all three.
- R3: A write to 0x15 sets the enable bits that have a 1 in the data. A write to 0x16 clears the enable bits that have a 1. Zeros leave a bit unchanged. A read of 0x15 returns the enable bitmap, and a read of 0x16 returns zero.
- R4: With type bit 1, a rising edge of the synchronized input latches the line when its high-polarity bit is 1. A falling edge latches it when its low-polarity bit is 1. With both bits set, either edge latches it.
- R5: With type bit 0, the line latches while the input is 1 if its high-polarity bit is set, and while the input is 0 if its low-polarity bit is set. With neither bit set it never latches.
- R6: A write to 0x14 clears the latched bits that have a 1 in the data, and zeros have no effect. A read of 0x18 returns the latched bits. Latching takes place whether or not the line is enabled.
- R7: When a detection condition and a clear of the same line fall in the same cycle, the latched bit stays set.
- R8: `irq_req` is high exactly when some line has both its latched bit and its enable bit set.
- R9: A read of 0x10 returns, for each line, the synchronized input level if the line is in edge mode, and the live level-detection condition if it is in level mode.
- R10: Reads of unmapped addresses (anything other than 0x10 to 0x16 and 0x18) return zero. Writes to 0x10, 0x18 or an unmapped address change no register.
- R11: A change of a raw input shows in the latched bit and in `irq_req` after the third rising clock edge that follows it: two edges of synchronization, then one edge of latching.
- R12: A two-byte write starting at 0x14 clears the latched bits named by the first byte and sets the enables named by the second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_irq | input | 8 | Asynchronous interrupt inputs, one per line |
| bus_sel | input | 1 | Register beat valid this cycle |
| bus_first | input | 1 | Beat starts an access; its address comes from bus_addr |
| bus_we | input | 1 | 1 = write beat, 0 = read beat |
| bus_addr | input | 8 | Start address of an access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read beat and held until the next one |
| irq_req | output | 1 | Aggregated interrupt request |

## Verification
Register writes take effect on the clock edge that accepts the beat. Read data is due one edge later, so the bench samples `bus_rdata` on the falling edge that follows the next rising edge. Input-driven results need three rising edges, and the bench holds each raw pattern for six cycles before it reads status, except in a directed latency test that checks `irq_req` is still low after the second edge and high after the third. Random configurations and input patterns are compared with the latched bits, the request and the real-time status that bench functions compute from the previous and new input values.

// File: rtl/line_irq_pkg.sv
// Package: register addresses and widths shared by the interrupt unit.
// Assumes one data byte per register and a byte-wide address space.
package line_irq_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] A_LIVE  = 8'h10;
    localparam logic [ADDR_W-1:0] A_TYPE  = 8'h11;
    localparam logic [ADDR_W-1:0] A_POLHI = 8'h12;
    localparam logic [ADDR_W-1:0] A_POLLO = 8'h13;
    localparam logic [ADDR_W-1:0] A_LCLR  = 8'h14;
    localparam logic [ADDR_W-1:0] A_ENSET = 8'h15;
    localparam logic [ADDR_W-1:0] A_ENCLR = 8'h16;
    localparam logic [ADDR_W-1:0] A_LSTS  = 8'h18;
endpackage

// File: rtl/line_irq_sync.sv
// Module: multi-stage synchronizer for the raw interrupt inputs.
// Assumes the inputs are asynchronous; the last stage is the only output.
module line_irq_sync #(
    parameter int LINES  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d_in,
    output logic [LINES-1:0] q_out
);
    logic [LINES-1:0] stg [STAGES];

    // Shift the inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/line_irq_detect.sv
// Module: per-line edge or level detection.
// Assumes s_in is synchronous to clk. It produces a one-cycle set condition per
// line and the live status bit (synchronized level for edge lines, the
// condition for level lines).
module line_irq_detect #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] s_in,
    input  logic [LINES-1:0] is_edge,
    input  logic [LINES-1:0] pol_hi,
    input  logic [LINES-1:0] pol_lo,
    output logic [LINES-1:0] set_cond,
    output logic [LINES-1:0] live
);
    logic [LINES-1:0] prev;

    // Remember last cycle's synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= s_in;
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        logic rise, fall, lvl;
        // Form the per-line edge and level terms.
        always_comb begin
            rise        = s_in[n] & ~prev[n];
            fall        = ~s_in[n] & prev[n];
            lvl         = (pol_hi[n] & s_in[n]) | (pol_lo[n] & ~s_in[n]);
            set_cond[n] = is_edge[n] ? ((pol_hi[n] & rise) | (pol_lo[n] & fall)) : lvl;
            live[n]     = is_edge[n] ? s_in[n] : lvl;
        end

        // A level line with no polarity selected must stay quiet (R5).
        assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_edge[n] && !pol_hi[n] && !pol_lo[n]) |-> !set_cond[n]);
        // An edge line fires only when the level moved (R4).
        assert_edgeonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (is_edge[n] && set_cond[n]) |-> (s_in[n] != prev[n]));
    end
endmodule

// File: rtl/line_irq_regs.sv
// Module: register port with auto-incrementing address, configuration,
// enable and latch storage. Assumes one beat per cycle at most; a beat with
// first=1 restarts the address from bus_addr.
module line_irq_regs
    import line_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              first,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  set_cond,
    input  logic [LINES-1:0]  live,
    output logic [LINES-1:0]  rdata,
    output logic [LINES-1:0]  cfg_edge,
    output logic [LINES-1:0]  cfg_hi,
    output logic [LINES-1:0]  cfg_lo,
    output logic [LINES-1:0]  en_q,
    output logic [LINES-1:0]  lat_q
);
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] eff;
    logic              wr, rd, mapped;
    logic [LINES-1:0]  clr_mask;
    logic [LINES-1:0]  rmux;

    // Resolve the beat's address and decode its kind.
    always_comb begin
        eff      = first ? addr : ptr;
        wr       = sel & we;
        rd       = sel & ~we;
        clr_mask = (wr && eff == A_LCLR) ? wdata : '0;
        mapped   = (eff >= A_LIVE && eff <= A_ENCLR) || eff == A_LSTS;
    end

    // Advance the access pointer past each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (sel) ptr <= eff + 1'b1;
    end

    // Load the detection configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_edge <= '0;
            cfg_hi   <= '0;
            cfg_lo   <= '0;
        end else if (wr) begin
            if (eff == A_TYPE)  cfg_edge <= wdata;
            if (eff == A_POLHI) cfg_hi   <= wdata;
            if (eff == A_POLLO) cfg_lo   <= wdata;
        end
    end

    // Set or clear enables through the paired addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)                        en_q <= '0;
        else if (wr && eff == A_ENSET)     en_q <= en_q | wdata;
        else if (wr && eff == A_ENCLR)     en_q <= en_q & ~wdata;
    end

    // Latch detected events; a new condition beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= (lat_q & ~clr_mask) | set_cond;
    end

    // Select the readable register at the beat's address.
    always_comb begin
        case (eff)
            A_LIVE:  rmux = live;
            A_TYPE:  rmux = cfg_edge;
            A_POLHI: rmux = cfg_hi;
            A_POLLO: rmux = cfg_lo;
            A_ENSET: rmux = en_q;
            A_LSTS:  rmux = lat_q;
            default: rmux = '0;
        endcase
    end

    // Register read data on read beats and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rmux;
    end

    // Cleared bits without a new condition end up low (R6).
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && eff == A_LCLR) |=> ((lat_q & $past(wdata & ~set_cond)) == '0));
    // Any condition leaves its latch set, even under a clear (R7).
    assert_setwins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_cond) |=> ((lat_q & $past(set_cond)) == $past(set_cond)));
    // Enable-set ones appear in the bitmap (R3).
    assert_enset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && eff == A_ENSET) |=> ((en_q & $past(wdata)) == $past(wdata)));
    // Writes to read-only or unmapped addresses change no setting (R10).
    assert_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (!mapped || eff == A_LIVE || eff == A_LSTS)) |=>
        ($stable(cfg_edge) && $stable(cfg_hi) && $stable(cfg_lo) && $stable(en_q)));
endmodule

// File: rtl/line_irq_unit.sv
// Module: top of the eight-line peripheral interrupt unit.
// Assumes raw_irq is asynchronous; all else is synchronous to clk with a
// synchronous active-low reset.
module line_irq_unit
    import line_irq_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  raw_irq,
    input  logic              bus_sel,
    input  logic              bus_first,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    output logic              irq_req
);
    logic [LINES-1:0] s_lvl, set_cond, live;
    logic [LINES-1:0] cfg_edge, cfg_hi, cfg_lo, en_q, lat_q;

    line_irq_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(raw_irq), .q_out(s_lvl));

    line_irq_detect #(.LINES(LINES)) det_i (
        .clk(clk), .rst_n(rst_n), .s_in(s_lvl), .is_edge(cfg_edge),
        .pol_hi(cfg_hi), .pol_lo(cfg_lo), .set_cond(set_cond), .live(live));

    line_irq_regs #(.LINES(LINES)) regs_i (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .first(bus_first), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .set_cond(set_cond), .live(live),
        .rdata(bus_rdata), .cfg_edge(cfg_edge), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
        .en_q(en_q), .lat_q(lat_q));

    // Combine enabled latched events into the single request.
    assign irq_req = |(lat_q & en_q);

    // No enabled line means no request (R8).
    assert_noirq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_req);
    // A latched and enabled line raises the request (R8).
    assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_cond & en_q) != '0 && $stable(en_q)) |-> irq_req);
endmodule

// File: tb/line_irq_unit_tb.sv
// Bench: directed corner cases plus seeded random configurations.
module line_irq_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] raw_irq = '0;
    logic       bus_sel = 1'b0, bus_first = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_req;
    int         checks = 0, fails = 0;
    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];

    always #2.5 clk = ~clk;

    line_irq_unit dut_i (.clk(clk), .rst_n(rst_n), .raw_irq(raw_irq), .bus_sel(bus_sel),
        .bus_first(bus_first), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req));

    function automatic logic [7:0] lvl_hits(logic [7:0] t, h, l, v);
        return ~t & ((h & v) | (l & ~v));
    endfunction
    function automatic logic [7:0] step_hits(logic [7:0] t, h, l, a, b);
        return (t & ((h & b & ~a) | (l & ~b & a))) | lvl_hits(t, h, l, b);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit we, input logic [7:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k > 0) rbuf[k-1] = bus_rdata;
            bus_sel = 1'b1; bus_first = (k == 0); bus_we = we;
            bus_addr = a; bus_wdata = wbuf[k];
        end
        @(negedge clk);
        rbuf[n-1] = bus_rdata;
        bus_sel = 1'b0; bus_first = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] d);
        wbuf[0] = d; xfer(1'b1, a, 1);
    endtask
    task automatic rd1(input logic [7:0] a, output logic [7:0] d);
        xfer(1'b0, a, 1); d = rbuf[0];
    endtask
    task automatic cfg3(input logic [7:0] t, h, l);
        wbuf[0] = t; wbuf[1] = h; wbuf[2] = l; xfer(1'b1, 8'h11, 3);
    endtask
    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'd5150));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq_req}, 8'h00);
        rd1(8'h11, r); chk("R1 type", r, 8'h00);
        rd1(8'h15, r); chk("R1 enable", r, 8'h00);
        rd1(8'h18, r); chk("R1 latched", r, 8'h00);

        // R2: burst write and burst read of configuration
        cfg3(8'ha5, 8'h3c, 8'h0f);
        xfer(1'b0, 8'h11, 3);
        chk("R2 type", rbuf[0], 8'ha5);
        chk("R2 polhi", rbuf[1], 8'h3c);
        chk("R2 pollo", rbuf[2], 8'h0f);
        cfg3(8'h00, 8'h00, 8'h00);
        wr1(8'h14, 8'hff);

        // R3: paired enable registers
        wr1(8'h15, 8'h0f); rd1(8'h15, r); chk("R3 set", r, 8'h0f);
        wr1(8'h16, 8'h03); rd1(8'h15, r); chk("R3 clear", r, 8'h0c);
        wr1(8'h15, 8'h00); rd1(8'h15, r); chk("R3 zero set", r, 8'h0c);
        rd1(8'h16, r); chk("R3 clear reads zero", r, 8'h00);

        // R10: ignored writes and unmapped reads
        wr1(8'h10, 8'hff); wr1(8'h18, 8'hff); wr1(8'h17, 8'hff); wr1(8'h40, 8'hff);
        rd1(8'h17, r); chk("R10 read 17", r, 8'h00);
        rd1(8'h00, r); chk("R10 read 00", r, 8'h00);
        rd1(8'h18, r); chk("R10 latched kept", r, 8'h00);
        xfer(1'b0, 8'h11, 3);
        chk("R10 type kept", rbuf[0], 8'h00);
        chk("R10 hi kept", rbuf[1], 8'h00);
        rd1(8'h15, r); chk("R10 enable kept", r, 8'h0c);

        // R11: latency of a rising edge to the request
        wr1(8'h16, 8'hff); cfg3(8'h01, 8'h01, 8'h00); wr1(8'h15, 8'h01);
        @(negedge clk) raw_irq = 8'h01;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R11 irq after two edges", {7'd0, irq_req}, 8'h00);
        @(negedge clk);
        chk("R11 irq after three edges", {7'd0, irq_req}, 8'h01);

        // R6: zero clear has no effect
        wr1(8'h14, 8'h00); rd1(8'h18, r); chk("R6 zero clear", r, 8'h01);

        // R12: clear latch and set enable in one access
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; xfer(1'b1, 8'h14, 2);
        rd1(8'h18, r); chk("R12 latch cleared", r, 8'h00);
        rd1(8'h15, r); chk("R12 enable set", r, 8'h03);
        chk("R12 irq low", {7'd0, irq_req}, 8'h00);

        // R4: both edges armed
        cfg3(8'h04, 8'h04, 8'h04); settle(); wr1(8'h14, 8'hff);
        raw_irq = 8'h05; settle(); rd1(8'h18, r); chk("R4 rise", r, 8'h04);
        wr1(8'h14, 8'h04);
        raw_irq = 8'h01; settle(); rd1(8'h18, r); chk("R4 fall", r, 8'h04);

        // R7 and R5: level lines, clear during active level
        cfg3(8'h00, 8'h08, 8'h00); raw_irq = 8'h08; settle();
        wr1(8'h14, 8'hff); rd1(8'h18, r); chk("R7 set beats clear", r, 8'h08);
        rd1(8'h10, r); chk("R9 level live", r, 8'h08);
        cfg3(8'h00, 8'h00, 8'h10); settle(); wr1(8'h14, 8'hff);
        rd1(8'h18, r); chk("R5 active low", r, 8'h10);
        rd1(8'h10, r); chk("R9 active low live", r, 8'h10);

        // R9: edge lines show the synchronized level
        cfg3(8'hff, 8'h00, 8'h00); raw_irq = 8'h5a; settle();
        rd1(8'h10, r); chk("R9 edge live", r, 8'h5a);

        // Random configurations and input steps (R4, R5, R6, R8, R9)
        for (int it = 0; it < 24; it++) begin
            logic [7:0] t, h, l, e, v0, v1, exp;
            t = 8'($urandom); h = 8'($urandom); l = 8'($urandom); e = 8'($urandom);
            v0 = 8'($urandom); v1 = 8'($urandom);
            cfg3(t, h, l);
            wr1(8'h16, 8'hff); wr1(8'h15, e);
            raw_irq = v0; settle();
            wr1(8'h14, 8'hff);
            raw_irq = v1; settle();
            exp = lvl_hits(t, h, l, v0) | step_hits(t, h, l, v0, v1);
            rd1(8'h18, r); chk("R4/R5 random latched", r, exp);
            chk("R8 random irq", {7'd0, irq_req}, {7'd0, |(exp & e)});
            rd1(8'h10, r); chk("R9 random live", r, (t & v1) | lvl_hits(t, h, l, v1));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule